// File: doc/BRIEF.md
# Core Test Wrapper Serial Controller

This block surrounds an embedded core with a serially accessed test wrapper. An external test controller drives discrete enables, not a state machine. The wrapper holds three serial registers:

- a 3-bit instruction register;
- a one-bit bypass stage;
- a boundary register with one cell per core terminal.

One steering input chooses between the instruction register and the data register that the active instruction names. Capture, shift, transfer and update enables then act on the chosen register. All serial traffic enters at `wsi` and leaves at `wso`, clocked by `wrck`.

In normal operation the boundary is transparent: pins reach the core inputs and core outputs reach the pins. Two test instructions change this. External test drives the pins from the boundary cells. Internal test drives the core inputs from the boundary cells. A preload instruction lets the boundary register be filled while the functional paths stay transparent. The values then take effect as soon as external or internal test is made active.

Shifting and capturing happen on the rising `wrck` edge. Updating happens on the falling edge. An asynchronous active-low reset puts the wrapper into normal mode, and its release is synchronised to `wrck`.

Top module: `core_test_wrapper`

## Requirements
- R1: While `wrst_n` is low, the active instruction is 000 and every boundary and bypass stage is 0. As a result `core_in` equals `pin_in`, `pin_out` equals `core_out` and `wso` is 0. Reset takes effect immediately and its release completes after two rising `wrck` edges.
- R2: With `sel_ir` high, a rising edge with `shift_en` moves the instruction shift stage one place toward `wso` and enters `wsi` at bit 2, so `wso` shows bit 0. A capture without shift loads the pattern 001.
- R3: The active instruction changes only on a falling edge where `sel_ir` and `update_en` are high and both `shift_en` and `capture_en` are low. It then takes the instruction shift stage.
- R4: Codes 000 and 100 to 111 select the one-bit bypass stage as the data register. Capture loads 0 into it, and each shift delays `wsi` by one rising edge on its way to `wso`.
- R5: Codes 001, 010 and 011 select the boundary register of NUM_IN+NUM_OUT cells. Cells 0 to NUM_IN-1 serve the core inputs and the cells above them serve the core outputs. Cell 0 drives `wso` and `wsi` enters the top cell.
- R6: A boundary capture loads each input cell from `pin_in` and each output cell from `core_out`.
- R7: Under code 001 (external test), `pin_out` takes the update stages of the output cells and `core_in` equals `pin_in`.
- R8: Under code 010 (internal test), `core_in` takes the update stages of the input cells and `pin_out` equals `core_out`.
- R9: Under code 011 (preload), the functional paths stay transparent while the boundary register is scanned and updated. Switching afterwards to code 001 applies the preloaded values to the pins without another scan.
- R10: Among rising-edge actions, shift beats capture and capture beats transfer. A falling-edge update is skipped whenever shift or capture is also asserted.
- R11: With the boundary register selected and `sel_ir` low, a transfer alone copies every cell's update stage into its shift stage. With `sel_ir` high, transfer leaves the boundary register untouched.
- R12: With `sel_ir` low, no enable changes the instruction shift stage or the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Wrapper clock |
| wrst_n | input | 1 | Asynchronous active-low wrapper reset |
| wsi | input | 1 | Serial data into the wrapper |
| sel_ir | input | 1 | High steers enables to the instruction register |
| capture_en | input | 1 | Capture enable for the selected register |
| shift_en | input | 1 | Shift enable for the selected register |
| update_en | input | 1 | Update enable, acted on at the falling edge |
| transfer_en | input | 1 | Copies boundary update stages into shift stages |
| wso | output | 1 | Serial data out of the wrapper |
| pin_in | input | NUM_IN | Functional inputs arriving from the pins |
| core_in | output | NUM_IN | Inputs delivered to the core |
| core_out | input | NUM_OUT | Outputs produced by the core |
| pin_out | output | NUM_OUT | Functional outputs delivered to the pins |

## Verification
The hardest situation to reach is two or three enables overlapping while the boundary register holds a known, non-captured pattern in its shift stage and a different pattern in its update stage. Only then does a lost update or a wrong winner become visible at `pin_out` or in the bits shifted out afterwards.

The stimulus reaches this state directly. It scans in one pattern with update, then shifts a second pattern without update. It then issues a cycle with all three enables high and a cycle with capture and update together, and reads the register back after each.

Transfer is reached the same way: the shift stage is cleared first, so a copied update stage stands out. Random rounds mix all eight instruction codes with random pins and shift data.

// File: rtl/cwrap_pkg.sv
package cwrap_pkg;
  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b000;
  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b001;
  localparam logic [IR_W-1:0] OP_INTEST  = 3'b010;
  localparam logic [IR_W-1:0] OP_PRELOAD = 3'b011;

  // Pattern loaded by an instruction capture; LSB set to prove chain continuity
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef struct packed {
    logic bsr_sel;     // boundary register is the data register
    logic drive_pins;  // output cells own pin_out
    logic drive_core;  // input cells own core_in
  } mode_t;

  function automatic mode_t decode_op(logic [IR_W-1:0] code);
    mode_t m;
    m = '0;
    case (code)
      OP_EXTEST:  begin m.bsr_sel = 1'b1; m.drive_pins = 1'b1; end
      OP_INTEST:  begin m.bsr_sel = 1'b1; m.drive_core = 1'b1; end
      OP_PRELOAD: begin m.bsr_sel = 1'b1; end
      default:    ;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cwrap_rst_sync.sv
module cwrap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_n  <= meta_q;
    end
  end
endmodule

// File: rtl/cwrap_instr_reg.sv
module cwrap_instr_reg
  import cwrap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            si,
  input  logic            shift_en,
  input  logic            capture_en,
  input  logic            update_en,
  output logic            so,
  output logic [IR_W-1:0] sh_q,
  output logic [IR_W-1:0] act_q
);
  logic [IR_W-1:0] sh_d;
  logic [IR_W-1:0] act_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en)
      sh_d = {si, sh_q[IR_W-1:1]};
    else if (capture_en)
      sh_d = IR_CAPTURE_PAT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    act_d = act_q;
    if (update_en) act_d = sh_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= OP_BYPASS;
    else        act_q <= act_d;
  end

  assign so = sh_q[0];
endmodule

// File: rtl/cwrap_bypass.sv
module cwrap_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic shift_en,
  input  logic capture_en,
  output logic so
);
  logic byp_q;
  logic byp_d;

  always_comb begin
    byp_d = byp_q;
    if (shift_en)        byp_d = si;
    else if (capture_en) byp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  assign so = byp_q;
endmodule

// File: rtl/cwrap_bcell.sv
module cwrap_bcell (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic shift_en,
  input  logic capture_en,
  input  logic transfer_en,
  input  logic update_en,
  input  logic func_in,
  output logic so,
  output logic hold_q
);
  logic sh_q, sh_d;
  logic hold_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en)         sh_d = si;
    else if (capture_en)  sh_d = func_in;
    else if (transfer_en) sh_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 1'b0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    hold_d = hold_q;
    if (update_en) hold_d = sh_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign so = sh_q;
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import cwrap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               wrck,
  input  logic               wrst_n,
  input  logic               wsi,
  input  logic               sel_ir,
  input  logic               capture_en,
  input  logic               shift_en,
  input  logic               update_en,
  input  logic               transfer_en,
  output logic               wso,
  input  logic [NUM_IN-1:0]  pin_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic [NUM_OUT-1:0] pin_out
);
  localparam int NCELL = NUM_IN + NUM_OUT;

  logic            rst_sync_n;
  logic [IR_W-1:0] ir_sh, ir_act;
  logic            ir_so, byp_so;
  mode_t           mode;
  logic [NCELL-1:0] chain, hold_vec;

  // Enable steering with shift > capture > transfer, update only when alone
  logic ir_shift, ir_cap, ir_upd;
  logic dr_bsr, dr_byp;
  logic bsr_shift, bsr_cap, bsr_tr, bsr_upd;
  logic byp_shift, byp_cap;
  logic quiet_edge;

  cwrap_rst_sync u_rst (
    .clk    (wrck),
    .arst_n (wrst_n),
    .rst_n  (rst_sync_n)
  );

  assign mode       = decode_op(ir_act);
  assign quiet_edge = ~shift_en & ~capture_en;

  assign ir_shift = sel_ir & shift_en;
  assign ir_cap   = sel_ir & capture_en & ~shift_en;
  assign ir_upd   = sel_ir & update_en & quiet_edge;

  assign dr_bsr = ~sel_ir & mode.bsr_sel;
  assign dr_byp = ~sel_ir & ~mode.bsr_sel;

  assign bsr_shift = dr_bsr & shift_en;
  assign bsr_cap   = dr_bsr & capture_en & ~shift_en;
  assign bsr_tr    = dr_bsr & transfer_en & quiet_edge;
  assign bsr_upd   = dr_bsr & update_en & quiet_edge;

  assign byp_shift = dr_byp & shift_en;
  assign byp_cap   = dr_byp & capture_en & ~shift_en;

  cwrap_instr_reg u_ir (
    .clk        (wrck),
    .rst_n      (rst_sync_n),
    .si         (wsi),
    .shift_en   (ir_shift),
    .capture_en (ir_cap),
    .update_en  (ir_upd),
    .so         (ir_so),
    .sh_q       (ir_sh),
    .act_q      (ir_act)
  );

  cwrap_bypass u_byp (
    .clk        (wrck),
    .rst_n      (rst_sync_n),
    .si         (wsi),
    .shift_en   (byp_shift),
    .capture_en (byp_cap),
    .so         (byp_so)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    logic cell_si, cell_fin;
    if (g == NCELL - 1) begin : g_head
      assign cell_si = wsi;
    end else begin : g_link
      assign cell_si = chain[g+1];
    end
    if (g < NUM_IN) begin : g_in
      assign cell_fin = pin_in[g];
    end else begin : g_out
      assign cell_fin = core_out[g-NUM_IN];
    end
    cwrap_bcell u_cell (
      .clk         (wrck),
      .rst_n       (rst_sync_n),
      .si          (cell_si),
      .shift_en    (bsr_shift),
      .capture_en  (bsr_cap),
      .transfer_en (bsr_tr),
      .update_en   (bsr_upd),
      .func_in     (cell_fin),
      .so          (chain[g]),
      .hold_q      (hold_vec[g])
    );
  end

  assign core_in = mode.drive_core ? hold_vec[NUM_IN-1:0]     : pin_in;
  assign pin_out = mode.drive_pins ? hold_vec[NCELL-1:NUM_IN] : core_out;

  always_comb begin
    if (sel_ir)            wso = ir_so;
    else if (mode.bsr_sel) wso = chain[0];
    else                   wso = byp_so;
  end
endmodule

// File: rtl/cwrap_checker.sv
module cwrap_checker
  import cwrap_pkg::*;
(
  input logic            wrck,
  input logic            rst_n,
  input logic            wsi,
  input logic            sel_ir,
  input logic            shift_en,
  input logic            capture_en,
  input logic            update_en,
  input logic [IR_W-1:0] ir_sh,
  input logic [IR_W-1:0] ir_act,
  input logic            chain_head,
  input logic            byp_q
);
  logic bsr_code;
  assign bsr_code = (ir_act == OP_EXTEST) || (ir_act == OP_INTEST) || (ir_act == OP_PRELOAD);

  AST_IR_SHIFT_TOWARD_OUT: assert property (@(posedge wrck) disable iff (!rst_n)
    (sel_ir && shift_en) |=> (ir_sh[IR_W-1] == $past(wsi)) && (ir_sh[IR_W-2:0] == $past(ir_sh[IR_W-1:1]))); // R2

  AST_ACT_CHANGES_ON_UPDATE_ONLY: assert property (@(negedge wrck) disable iff (!rst_n)
    !$past(sel_ir && update_en && !shift_en && !capture_en) |-> $stable(ir_act)); // R3

  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge wrck) disable iff (!rst_n)
    (!sel_ir && capture_en && !shift_en && !bsr_code) |=> !byp_q); // R4

  AST_SHIFT_BEATS_CAPTURE: assert property (@(posedge wrck) disable iff (!rst_n)
    (!sel_ir && shift_en && bsr_code) |=> chain_head == $past(wsi)); // R10

  AST_IR_IDLE_WHEN_DESELECTED: assert property (@(posedge wrck) disable iff (!rst_n)
    !sel_ir |=> $stable(ir_sh)); // R12
endmodule

bind core_test_wrapper cwrap_checker u_chk (
  .wrck       (wrck),
  .rst_n      (rst_sync_n),
  .wsi        (wsi),
  .sel_ir     (sel_ir),
  .shift_en   (shift_en),
  .capture_en (capture_en),
  .update_en  (update_en),
  .ir_sh      (ir_sh),
  .ir_act     (ir_act),
  .chain_head (chain[NCELL-1]),
  .byp_q      (byp_so)
);

// File: tb/tb_core_test_wrapper.sv
module tb_core_test_wrapper;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int N  = NI + NO;

  logic wrck = 1'b0;
  logic wrst_n, wsi, sel_ir, capture_en, shift_en, update_en, transfer_en;
  logic wso;
  logic [NI-1:0] pin_in, core_in;
  logic [NO-1:0] core_out, pin_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) wrck = ~wrck;

  core_test_wrapper #(.NUM_IN(NI), .NUM_OUT(NO)) dut (
    .wrck(wrck), .wrst_n(wrst_n), .wsi(wsi), .sel_ir(sel_ir),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .transfer_en(transfer_en), .wso(wso), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic sh, input logic cap,
                       input logic upd, input logic tr, input logic di);
    sel_ir = s; shift_en = sh; capture_en = cap; update_en = upd; transfer_en = tr; wsi = di;
  endtask

  // One falling edge then one rising edge with fixed controls; returns at rise+1
  task automatic step(input logic s, input logic sh, input logic cap,
                      input logic upd, input logic tr, input logic di);
    drive(s, sh, cap, upd, tr, di);
    @(posedge wrck); #1;
  endtask

  task automatic ir_load(input logic [2:0] code, output logic [2:0] cap_out);
    step(1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1, 1, 0, 0, 0, code[i]); #1;
      cap_out[i] = wso;
      @(posedge wrck); #1;
    end
    step(1, 0, 0, 1, 0, 0);
  endtask

  task automatic dr_shift(input logic [N-1:0] din, output logic [N-1:0] dout);
    for (int i = 0; i < N; i++) begin
      drive(0, 1, 0, 0, 0, din[i]); #1;
      dout[i] = wso;
      @(posedge wrck); #1;
    end
  endtask

  task automatic dr_scan(input logic [N-1:0] din, output logic [N-1:0] dout);
    step(0, 0, 1, 0, 0, 0);
    dr_shift(din, dout);
    step(0, 0, 0, 1, 0, 0);
  endtask

  function automatic logic is_bsr(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic logic [N-1:0] exp_capture(input logic [NI-1:0] p, input logic [NO-1:0] c);
    return {c, p};
  endfunction

  function automatic logic [NI-1:0] exp_core_in(input logic [2:0] c, input logic [N-1:0] u, input logic [NI-1:0] p);
    return (c == 3'b010) ? u[NI-1:0] : p;
  endfunction

  function automatic logic [NO-1:0] exp_pin_out(input logic [2:0] c, input logic [N-1:0] u, input logic [NO-1:0] co);
    return (c == 3'b001) ? u[N-1:NI] : co;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [2:0]   irc;
    logic [N-1:0] dout, upd_m, pat;
    logic [2:0]   code;
    void'($urandom(32'd20240611));
    wrst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    pin_in = 4'hA; core_out = 4'h5;
    #(CLK_PERIOD * 2 + 3);
    chk("R1 core_in transparent in reset", core_in, 4'hA);
    chk("R1 pin_out transparent in reset", pin_out, 4'h5);
    chk("R1 wso low in reset", wso, 0);
    wrst_n = 1'b1;
    repeat (3) @(posedge wrck);
    #1;

    // R2 capture pattern and R5/R6/R7 external test
    ir_load(3'b001, irc);
    chk("R2 instruction capture pattern", irc, 3'b001);
    pin_in = 4'h3; core_out = 4'hC;
    pat = 8'h96;
    dr_scan(pat, dout);
    chk("R6 boundary capture order", dout, exp_capture(4'h3, 4'hC));
    upd_m = pat;
    chk("R7 pins driven by cells", pin_out, upd_m[N-1:NI]);
    chk("R7 core_in transparent", core_in, 4'h3);

    // R10 all enables at once: shift wins, no update
    dr_shift(8'h5A, dout);
    step(0, 1, 1, 1, 0, 1);
    chk("R10 update blocked by shift", pin_out, upd_m[N-1:NI]);
    dr_shift('0, dout);
    chk("R10 shift won over capture", dout, {1'b1, 7'h2D});
    step(0, 0, 1, 1, 0, 0);
    chk("R10 update blocked by capture", pin_out, upd_m[N-1:NI]);
    dr_shift('0, dout);
    chk("R10 capture taken", dout, exp_capture(4'h3, 4'hC));

    // R11 transfer ignored when instruction register selected, then effective
    step(1, 0, 0, 0, 1, 0);
    dr_shift('0, dout);
    chk("R11 transfer ignored with sel_ir", dout, 0);
    step(0, 0, 0, 0, 1, 0);
    dr_shift('0, dout);
    chk("R11 transfer copies update stage", dout, upd_m);
    chk("R12 still external test after DR ops", pin_out, upd_m[N-1:NI]);

    // R3 shifting an instruction without update keeps the old one
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, (3'b010 >> i) & 1'b1);
    chk("R3 no update keeps external test", pin_out, upd_m[N-1:NI]);
    step(1, 0, 0, 1, 0, 0);
    chk("R8 core_in from cells", core_in, upd_m[NI-1:0]);
    chk("R8 pin_out transparent", pin_out, 4'hC);

    // R9 preload then external test
    ir_load(3'b011, irc);
    pat = 8'hE1;
    dr_scan(pat, dout);
    chk("R9 preload keeps pins transparent", pin_out, 4'hC);
    chk("R9 preload keeps core transparent", core_in, 4'h3);
    upd_m = pat;
    ir_load(3'b001, irc);
    chk("R9 preloaded values reach pins", pin_out, 4'hE);

    // R1 asynchronous reset mid-test
    wrst_n = 1'b0; #2;
    chk("R1 async reset restores normal", pin_out, 4'hC);
    @(posedge wrck); #1;
    wrst_n = 1'b1;
    repeat (3) @(posedge wrck);
    #1;
    upd_m = '0;

    // Random rounds across all instruction codes
    for (int it = 0; it < 40; it++) begin
      code = 3'($urandom_range(0, 7));
      pin_in = 4'($urandom); core_out = 4'($urandom);
      pat = 8'($urandom);
      ir_load(code, irc);
      chk("R2 capture pattern", irc, 3'b001);
      dr_scan(pat, dout);
      if (is_bsr(code)) begin
        chk("R5 R6 boundary readout", dout, exp_capture(pin_in, core_out));
        upd_m = pat;
      end else begin
        chk("R4 bypass delay", dout, {pat[N-2:0], 1'b0});
      end
      chk("R7 R8 core_in", core_in, exp_core_in(code, upd_m, pin_in));
      chk("R7 R8 pin_out", pin_out, exp_pin_out(code, upd_m, core_out));
    end

    finish_run();
  end
endmodule